// File: doc/BRIEF.md
# FIFO-Buffered Serial Transmitter with Flow Control

This block turns bytes written into a 16-entry queue into asynchronous serial frames on a single output line. Each frame is a low start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The bit time comes from a prescaler with four ratios (1, 4, 16, 64) followed by a programmable bit-rate counter. The line stays high whenever nothing is being sent.

The client sees the queue fill level, a flag that rises once the queue has drained to a selectable low-water level, and a completion flag that rises only after the last frame has fully left the line. When flow control is switched on, a clear-to-send input must be high before each new frame may begin. A frame already under way always finishes. A break control replaces the line value with a level chosen by software, and a synchronous clear empties the queue.

Top module: `fifo_uart_tx`

## Requirements
- R1: After reset the line `txd` is 1, `fill_count` is 0, and both `below_thr` and `tx_done` are 1.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the stop bits (1). With `char7`=1 only `wr_data[6:0]` is sent and bit 7 is ignored. With `char7`=0 all 8 bits are sent.
- R3: With `parity_en`=1, one parity bit follows the data bits. It makes the count of ones over the data and parity bits even when `parity_odd`=0, and odd when `parity_odd`=1.
- R4: `two_stop`=1 gives two stop bits and `two_stop`=0 gives one. Back-to-back frames start L*P+1 clock cycles apart, where L is the frame length in bits and P is the bit period.
- R5: The bit period P is (`bit_div`+1) times the prescale ratio. The ratio is 1, 4, 16 or 64 for `clk_sel` codes 0, 1, 2 and 3.
- R6: `fill_count` reports the queue occupancy from 0 to 16. A write while 16 entries are held is ignored. The first 16 entries are sent in write order.
- R7: `below_thr` is 1 exactly when `fill_count` is at most 8, 4, 2 or 1, for `thr_sel` codes 0, 1, 2 and 3.
- R8: `tx_done` is 0 while a frame is on the line, including its final stop bit. It is 1 only once the queue is empty and the last stop bit has ended.
- R9: With `flow_en`=1 and `cts_ok`=0, no new frame starts. A frame already started when `cts_ok` falls is sent completely.
- R10: While `brk_force`=1, `txd` equals `brk_level`.
- R11: A one-cycle `fifo_clear` sets `fill_count` to 0, and the discarded entries are never sent.
- R12: With `tx_enable`=1 and an empty queue, `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Character to queue |
| tx_enable | input | 1 | Allow frames to start |
| char7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits |
| clk_sel | input | 2 | Prescale code: divide by 1/4/16/64 |
| bit_div | input | 8 | Bit-rate counter limit; bit period is (value+1) prescaled ticks |
| thr_sel | input | 2 | Low-water code: 8/4/2/1 entries |
| flow_en | input | 1 | Gate each frame start on `cts_ok` |
| cts_ok | input | 1 | Peer ready to receive |
| fifo_clear | input | 1 | Discard all queued entries |
| brk_force | input | 1 | Override the line with `brk_level` |
| brk_level | input | 1 | Line level while overridden |
| txd | output | 1 | Serial output |
| fill_count | output | 5 | Queue occupancy, 0 to 16 |
| below_thr | output | 1 | Occupancy is at or below the selected level |
| tx_done | output | 1 | Queue empty and the line is finished |

## Verification
The bench sweeps every fill level from 0 to 16 against all four low-water codes. A comparison of the wrong sense or off by one would flip `below_thr` at the 8, 4, 2 or 1 boundary. It also pushes a seventeenth write, which a design without a full guard would accept, wrapping the count or overwriting the oldest entry.

Frame spacing is timed against an arithmetic L*P+1 for the shortest and the longest frame formats, so a dropped or extra stop bit shows as a wrong interval. Start-bit widths are measured for each prescale code. The bench also looks at three behaviours that break easily:
- `tx_done` sampled during the final stop bit catches a flag that ignores the shifter.
- Dropping `cts_ok` mid-frame catches a transmitter that aborts the frame or keeps starting new ones.
- A cleared queue followed by a new write catches stale entries leaking out.

// File: rtl/uart_tx_pkg.sv
// Package: shared types and helpers for the serial transmitter.
// Assumes: prescale codes and low-water codes are 2 bits wide.
package uart_tx_pkg;

    typedef enum logic [1:0] {
        PRESC_1  = 2'd0,
        PRESC_4  = 2'd1,
        PRESC_16 = 2'd2,
        PRESC_64 = 2'd3
    } presc_e;

    // Last value of the prescale counter for a code (ratio minus one).
    function automatic logic [5:0] presc_last(input presc_e sel);
        case (sel)
            PRESC_1:  presc_last = 6'd0;
            PRESC_4:  presc_last = 6'd3;
            PRESC_16: presc_last = 6'd15;
            default:  presc_last = 6'd63;
        endcase
    endfunction

    // Low-water level selected by a code: 8, 4, 2 or 1 entries.
    function automatic logic [4:0] thr_level(input logic [1:0] code);
        thr_level = 5'd8 >> code;
    endfunction

endpackage

// File: rtl/tx_baud_gen.sv
// Module: bit-time generator. A prescaler (1/4/16/64) feeds a counter
// that wraps after bit_div+1 prescaled ticks and emits a one-cycle bit_tick.
// Assumes: both counters are held at zero while run is low, so the first
// bit after a start lasts a full period.
module tx_baud_gen
    import uart_tx_pkg::*;
#(
    parameter int BRR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       clk_sel,
    input  logic [BRR_W-1:0] bit_div,
    output logic             bit_tick
);

    localparam int PRE_W = 6;

    logic [PRE_W-1:0] pre_cnt;
    logic [BRR_W-1:0] rate_cnt;
    logic [PRE_W-1:0] pre_limit;
    logic             pre_tick;

    assign pre_limit = presc_last(presc_e'(clk_sel));
    assign pre_tick  = run && (pre_cnt == pre_limit);
    assign bit_tick  = pre_tick && (rate_cnt == bit_div);

    // Prescale counter: wraps at the selected ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Bit-rate counter: advances on each prescaled tick, wraps at bit_div.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            rate_cnt <= '0;
        end else if (pre_tick) begin
            if (rate_cnt == bit_div) begin
                rate_cnt <= '0;
            end else begin
                rate_cnt <= rate_cnt + 1'b1;
            end
        end
    end

    // R5: the rate counter never passes its programmed limit while running
    // with a stable limit.
    p_rate_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run && $stable(bit_div) && rate_cnt <= bit_div |=> rate_cnt <= bit_div);

endmodule

// File: rtl/tx_fifo.sv
// Module: synchronous first-in first-out queue for transmit characters.
// Assumes: pop is only raised when the queue is not empty; a write while
// full is dropped; clear wins over a same-cycle write or pop.
module tx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic              clear,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH):0] count,
    output logic              empty,
    output logic              full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_wr;
    logic              do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_wr   = wr_en && !full && !clear;
    assign do_rd   = pop && !empty && !clear;
    assign rd_data = mem[rd_ptr];

    // Storage: one register per entry, written at the write pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_wr && (wr_ptr == PTR_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    // Pointers and occupancy: advance on accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_full_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !pop && !clear |=> count == CNT_W'(DEPTH));

    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);

endmodule

// File: rtl/tx_shifter.sv
// Module: frame builder and bit shifter. On load it assembles start, data
// (LSB first), optional parity and stop bits into one register, then shifts
// one bit out per bit_tick. The format is captured at load time.
// Assumes: load is only raised while idle.
module tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] char_in,
    input  logic              char7,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              bit_tick,
    output logic              busy,
    output logic              line_out
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   frame_len;
    logic [LEN_W-1:0]   bits_left;
    logic               par_bit;
    int                 ndata;

    // Frame assembly: start 0, data LSB first, parity, stop ones.
    always_comb begin
        ndata   = char7 ? DATA_W - 1 : DATA_W;
        par_bit = (char7 ? ^char_in[DATA_W-2:0] : ^char_in) ^ parity_odd;
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < ndata) frame[i+1] = char_in[i];
        end
        if (parity_en) frame[ndata+1] = par_bit;
        frame_len = LEN_W'(1 + ndata) + LEN_W'(parity_en) + (two_stop ? LEN_W'(2) : LEN_W'(1));
    end

    // Shift state: load a frame, then drop one bit per bit_tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (load && !busy) begin
            shreg     <= frame;
            bits_left <= frame_len;
            busy      <= 1'b1;
        end else if (busy && bit_tick) begin
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == LEN_W'(1)) busy <= 1'b0;
        end
    end

    assign line_out = busy ? shreg[0] : 1'b1;

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load && !busy |=> line_out == 1'b0);

    p_busy_has_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bits_left != '0);

    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load && !busy |=> bits_left >= LEN_W'(DATA_W + 1) && bits_left <= LEN_W'(FRAME_W));

endmodule

// File: rtl/fifo_uart_tx.sv
// Module: top of the serial transmitter. Ties the queue, the bit-time
// generator and the shifter together; gates frame starts on enable and,
// when flow control is on, on cts_ok; applies the break override.
// Assumes: configuration is stable while a frame is being sent.
module fifo_uart_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int BRR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              char7,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic [1:0]        clk_sel,
    input  logic [BRR_W-1:0]  bit_div,
    input  logic [1:0]        thr_sel,
    input  logic              flow_en,
    input  logic              cts_ok,
    input  logic              fifo_clear,
    input  logic              brk_force,
    input  logic              brk_level,
    output logic              txd,
    output logic [$clog2(DEPTH):0] fill_count,
    output logic              below_thr,
    output logic              tx_done
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [DATA_W-1:0] head;
    logic              q_empty;
    logic              q_full;
    logic              busy;
    logic              line_out;
    logic              bit_tick;
    logic              start_ok;

    // Start gate: enabled, data queued, peer ready, shifter idle.
    assign start_ok = tx_enable && !q_empty && !busy && (!flow_en || cts_ok);

    tx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (start_ok),
        .clear   (fifo_clear),
        .rd_data (head),
        .count   (fill_count),
        .empty   (q_empty),
        .full    (q_full)
    );

    tx_baud_gen #(.BRR_W(BRR_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .clk_sel  (clk_sel),
        .bit_div  (bit_div),
        .bit_tick (bit_tick)
    );

    tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .char_in    (head),
        .char7      (char7),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .bit_tick   (bit_tick),
        .busy       (busy),
        .line_out   (line_out)
    );

    // Status and line output.
    assign below_thr = (fill_count <= CNT_W'(thr_level(thr_sel)));
    assign tx_done   = q_empty && !busy;
    assign txd       = brk_force ? brk_level : line_out;

    p_cts_holds_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flow_en && !cts_ok && !busy |=> !busy);

    p_done_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !brk_force |-> txd == 1'b1);

    p_full_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !below_thr);

endmodule

// File: tb/fifo_uart_tx_test.sv
module fifo_uart_tx_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_enable = 1'b0;
    logic       char7 = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [7:0] bit_div = 8'd3;
    logic [1:0] thr_sel = 2'd0;
    logic       flow_en = 1'b0;
    logic       cts_ok = 1'b1;
    logic       fifo_clear = 1'b0;
    logic       brk_force = 1'b0;
    logic       brk_level = 1'b0;
    logic       txd;
    logic [4:0] fill_count;
    logic       below_thr;
    logic       tx_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    fifo_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .char7(char7), .parity_en(parity_en),
        .parity_odd(parity_odd), .two_stop(two_stop), .clk_sel(clk_sel),
        .bit_div(bit_div), .thr_sel(thr_sel), .flow_en(flow_en), .cts_ok(cts_ok),
        .fifo_clear(fifo_clear), .brk_force(brk_force), .brk_level(brk_level),
        .txd(txd), .fill_count(fill_count), .below_thr(below_thr), .tx_done(tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int period();
        return (int'(bit_div) + 1) * (1 << (2 * int'(clk_sel)));
    endfunction

    function automatic int frame_len();
        return 1 + (char7 ? 7 : 8) + int'(parity_en) + (two_stop ? 2 : 1);
    endfunction

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_start(output int t0, output bit seen);
        seen = 1'b0; t0 = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (txd == 1'b0) begin seen = 1'b1; t0 = cyc; break; end
        end
    endtask

    // Receive one frame, sampling mid-bit, and check it against exp.
    task automatic expect_char(input logic [7:0] exp, input string req, output int t0);
        int p = period();
        int nd = char7 ? 7 : 8;
        int ns = two_stop ? 2 : 1;
        logic [7:0] got = '0;
        logic pbit = 1'b0;
        logic stop_ok = 1'b1;
        logic [7:0] expd = char7 ? {1'b0, exp[6:0]} : exp;
        bit seen;
        wait_start(t0, seen);
        chk(seen, req, "start bit seen", seen, 1);
        if (seen) begin
            repeat (p / 2) @(negedge clk);
            chk(txd == 1'b0, req, "start bit mid", txd, 0);
            for (int i = 0; i < nd; i++) begin
                repeat (p) @(negedge clk);
                got[i] = txd;
            end
            chk(got == expd, req, "data", got, expd);
            if (parity_en) begin
                repeat (p) @(negedge clk);
                pbit = txd;
                chk(pbit == ((^expd) ^ parity_odd), "R3", "parity bit", pbit, (^expd) ^ parity_odd);
            end
            for (int s = 0; s < ns; s++) begin
                repeat (p) @(negedge clk);
                stop_ok &= txd;
            end
            chk(stop_ok == 1'b1, "R4", "stop bits high", stop_ok, 1);
        end
    endtask

    task automatic clear_q();
        @(negedge clk); fifo_clear = 1'b1;
        @(negedge clk); fifo_clear = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t1, t2, lowlen;
        bit seen, stayed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(txd == 1'b1, "R1", "txd idle", txd, 1);
        chk(fill_count == 5'd0, "R1", "fill_count", fill_count, 0);
        chk(below_thr == 1'b1, "R1", "below_thr", below_thr, 1);
        chk(tx_done == 1'b1, "R1", "tx_done", tx_done, 1);

        // R7, R6: sweep every fill level against every low-water code
        for (int n = 0; n <= 16; n++) begin
            chk(fill_count == 5'(n), "R6", "fill_count", fill_count, n);
            for (int c = 0; c < 4; c++) begin
                thr_sel = 2'(c);
                @(negedge clk);
                chk(below_thr == (n <= (8 >> c)), "R7", "below_thr", below_thr, n <= (8 >> c));
            end
            push(8'(n * 7 + 3));
        end
        // 17th write above was into a full queue: R6 ignored
        chk(fill_count == 5'd16, "R6", "fill after write to full", fill_count, 16);

        // R6, R2: drain in order, 8N1
        tx_enable = 1'b1;
        for (int n = 0; n < 16; n++) begin
            expect_char(8'(n * 7 + 3), "R6", t1);
        end
        repeat (period()) @(negedge clk);
        chk(fill_count == 5'd0, "R6", "drained", fill_count, 0);

        // R12: idle high with empty queue
        stayed = 1'b1;
        repeat (40) begin @(negedge clk); stayed &= txd; end
        chk(stayed, "R12", "idle high", stayed, 1);

        // R2, R3, R4: 7 data bits, no parity, one stop; bit 7 ignored
        tx_enable = 1'b0; char7 = 1'b1;
        push(8'hD5); push(8'h2A);
        tx_enable = 1'b1;
        expect_char(8'hD5, "R2", t1);
        expect_char(8'h2A, "R2", t2);
        chk(t2 - t1 == frame_len() * period() + 1, "R4", "spacing 7N1", t2 - t1, frame_len() * period() + 1);

        // R3, R4: 8 data, even then odd parity, two stops
        tx_enable = 1'b0; char7 = 1'b0; parity_en = 1'b1; two_stop = 1'b1;
        for (int od = 0; od < 2; od++) begin
            parity_odd = od[0];
            push(8'h96); push(8'h07);
            tx_enable = 1'b1;
            expect_char(8'h96, "R3", t1);
            expect_char(8'h07, "R3", t2);
            chk(t2 - t1 == frame_len() * period() + 1, "R4", "spacing 8P2", t2 - t1, frame_len() * period() + 1);
            tx_enable = 1'b0;
            repeat (2 * period()) @(negedge clk);
        end
        parity_en = 1'b0; two_stop = 1'b0; parity_odd = 1'b0;

        // R5: start-bit width for each prescale code
        for (int c = 0; c < 4; c++) begin
            clk_sel = 2'(c);
            bit_div = (c == 1) ? 8'd2 : 8'd1;
            push(8'hFF);
            tx_enable = 1'b1;
            wait_start(t1, seen);
            lowlen = 0;
            while (txd == 1'b0 && lowlen < 1000) begin lowlen++; @(negedge clk); end
            chk(lowlen == period(), "R5", "start bit width", lowlen, period());
            while (tx_done == 1'b0) @(negedge clk);
            tx_enable = 1'b0;
        end
        clk_sel = 2'd0; bit_div = 8'd3;

        // R8: done low during the last stop bit, high after it
        push(8'h5A);
        tx_enable = 1'b1;
        expect_char(8'h5A, "R8", t1);
        chk(tx_done == 1'b0, "R8", "tx_done in stop bit", tx_done, 0);
        repeat (period()) @(negedge clk);
        chk(tx_done == 1'b1, "R8", "tx_done after frame", tx_done, 1);

        // R9: cts low holds the start
        tx_enable = 1'b0; flow_en = 1'b1; cts_ok = 1'b0;
        push(8'h33);
        tx_enable = 1'b1;
        stayed = 1'b1;
        repeat (60) begin @(negedge clk); stayed &= txd; end
        chk(stayed && fill_count == 5'd1, "R9", "held by cts", fill_count, 1);
        cts_ok = 1'b1;
        expect_char(8'h33, "R9", t1);
        // R9: cts drops mid-frame; frame completes, next is held
        tx_enable = 1'b0;
        push(8'hC1); push(8'h4E);
        tx_enable = 1'b1;
        fork
            expect_char(8'hC1, "R9", t1);
            begin
                wait_start(t2, seen);
                repeat (6) @(negedge clk);
                cts_ok = 1'b0;
            end
        join
        stayed = 1'b1;
        repeat (60) begin @(negedge clk); stayed &= txd; end
        chk(stayed && fill_count == 5'd1, "R9", "next start held", fill_count, 1);
        cts_ok = 1'b1;
        expect_char(8'h4E, "R9", t1);
        flow_en = 1'b0;

        // R10: break override
        tx_enable = 1'b0;
        repeat (period()) @(negedge clk);
        brk_force = 1'b1; brk_level = 1'b0;
        @(negedge clk);
        chk(txd == 1'b0, "R10", "break low", txd, 0);
        brk_level = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R10", "break high", txd, 1);
        brk_force = 1'b0;

        // R11: clear discards queued entries
        push(8'h11); push(8'h22); push(8'h44);
        clear_q();
        chk(fill_count == 5'd0, "R11", "count after clear", fill_count, 0);
        tx_enable = 1'b1;
        stayed = 1'b1;
        repeat (60) begin @(negedge clk); stayed &= txd; end
        chk(stayed && tx_done, "R11", "nothing sent after clear", stayed, 1);
        push(8'h3C);
        expect_char(8'h3C, "R11", t1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule